// File: doc/BRIEF.md
# BCD Real-Time Calendar Core with Frozen Read Copy and Staged Load

This block keeps the time of day and the calendar date in packed BCD. The fields are seconds, minutes, hours, day of week, day of month, month and two-digit year. Every accepted 1 Hz tick advances the seconds. Carries ripple through the fields and stop at the year. The day of month rolls over at the length of the current month, and February gets a 29th day in years divisible by four.

Software reaches the block through a flat byte-wide register port with address 0 as control and addresses 1 to 7 as the seven time fields.
- **Writes to fields:** a write to a field address lands in a staging copy. The running counters do not see it.
- **Committing a new time:** raising the commit bit of the control register freezes the counters. Clearing it copies the staged time into them in one step, and counting then resumes from there.
- **Reading the time:** reads of the field addresses return a frozen copy. That copy is refreshed only when the freeze bit of the control register goes from 0 to 1. A multi-byte read is therefore always consistent, while the counters keep running.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the field addresses read seconds 00, minutes 00, hours 00, day of week 1, date 01, month 01, year 00, and the control register reads 00.
- R2: Seconds and minutes count 00..59 in BCD and pass a carry when wrapping from 59 to 00. Hours count 00..23, and the 23-to-00 wrap advances both the date and the day of week.
- R3: Day of week counts 1..7 and wraps from 7 back to 1 on each day carry.
- R4: The date wraps to 01 and advances the month after 31 in months 01, 03, 05, 07, 08, 10, 12 and after 30 in months 04, 06, 09, 11.
- R5: In month 02 the date wraps after 29 when the BCD year, taken as a binary number, is divisible by 4 (year 00 included), and after 28 otherwise.
- R6: The month wraps from 12 to 01 and then advances the year; the year wraps from 99 to 00.
- R7: Field writes (address 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year) change only the staging copy. Neither the counters nor the values read back are affected. Writes to addresses 8..15 are ignored, and those addresses read 00.
- R8: While control bit 1 (commit) is 1, the counters hold their value and every tick on those edges is discarded. A tick on the same edge as the write that sets the bit is still counted.
- R9: A control write that clears bit 1 while it is set copies all seven staged fields into the counters on that edge. The next tick advances from the copied values.
- R10: A control write that turns bit 0 (freeze) from 0 to 1 captures the counters into the read copy on that edge. A tick on the same edge is not included in the copy.
- R11: While bit 0 stays 1, including writes that rewrite it as 1, the read copy does not change however many ticks arrive.
- R12: Address 0 reads back the two control bits in bits 1:0 with bits 7:2 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second that advances the time |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register address (0 control, 1..7 time fields) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |

## Verification
Every state change, including a tick, a staging write, the commit copy and the freeze capture, takes effect on the rising edge that samples the strobe. Read data is a pure multiplexer of registered state, so each result can be read back during the cycle that follows.

The bench drives strobes on the falling edge, so each strobe is sampled by exactly one rising edge. It reads by setting the address on the next falling edge and sampling one time unit later, well away from any rising edge.

The time counters are observed through the freeze/read sequence of the register port. A check made during a commit lock keeps bit 1 set while it pulses bit 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;

  localparam int SEC_W   = 7;
  localparam int MIN_W   = 7;
  localparam int HOUR_W  = 6;
  localparam int DOW_W   = 3;
  localparam int DATE_W  = 6;
  localparam int MONTH_W = 5;
  localparam int YEAR_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DOW   = 4'd4;
  localparam logic [ADDR_W-1:0] A_DATE  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MONTH = 4'd6;
  localparam logic [ADDR_W-1:0] A_YEAR  = 4'd7;

  localparam int CTRL_FREEZE = 0;
  localparam int CTRL_COMMIT = 1;

  typedef struct packed {
    logic [SEC_W-1:0]   sec;
    logic [MIN_W-1:0]   min;
    logic [HOUR_W-1:0]  hour;
    logic [DOW_W-1:0]   dow;
    logic [DATE_W-1:0]  date;
    logic [MONTH_W-1:0] month;
    logic [YEAR_W-1:0]  year;
  } rtc_time_t;

  // One BCD step of a two-digit value; a units digit of 9 carries.
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    logic [3:0] lo;
    logic [3:0] hi;
    lo = v[3:0];
    hi = v[7:4];
    if (lo >= 4'd9) return {hi + 4'd1, 4'd0};
    return {hi, lo + 4'd1};
  endfunction

  // Divisibility by four of a two-digit BCD year.
  function automatic logic year_has_feb29(input logic [7:0] y);
    logic [7:0] bin;
    bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return (bin[1:0] == 2'b00);
  endfunction

  // Last valid date, in BCD, of a BCD month within a BCD year.
  function automatic logic [DATE_W-1:0] last_date(input logic [MONTH_W-1:0] m,
                                                  input logic [YEAR_W-1:0]  y);
    case (m)
      5'h02:                      return year_has_feb29(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic rtc_time_t time_at_reset();
    rtc_time_t t;
    t.sec   = '0;
    t.min   = '0;
    t.hour  = '0;
    t.dow   = 3'd1;
    t.date  = 6'h01;
    t.month = 5'h01;
    t.year  = '0;
    return t;
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int           W       = 7,
  parameter logic [W-1:0] MIN_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic [W-1:0] max_val,
  output logic [W-1:0] val,
  output logic         wrap
);
  import rtc_pkg::*;

  logic [7:0] widened;
  logic [7:0] stepped;

  assign widened = 8'(val);
  assign stepped = bcd_step(widened);
  assign wrap    = inc && (val == max_val);

  always_ff @(posedge clk) begin
    if (!rst_n)     val <= MIN_VAL;
    else if (load)  val <= load_val;
    else if (inc)   val <= wrap ? MIN_VAL : stepped[W-1:0];
  end

  // R8
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(val));

  // R2
  field_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load) |=> (val == MIN_VAL));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      lock,
  input  logic      load,
  input  rtc_time_t load_time,
  output rtc_time_t cur_time,
  output logic      tick_taken,
  output logic      day_roll,
  output logic      month_roll
);

  logic sec_wrap, min_wrap, hour_wrap, dow_wrap, date_wrap, month_wrap, year_wrap;
  logic [DATE_W-1:0] date_limit;

  assign tick_taken = tick && !lock && !load;
  assign date_limit = last_date(cur_time.month, cur_time.year);
  assign day_roll   = hour_wrap;
  assign month_roll = date_wrap;

  rtc_bcd_field #(.W(SEC_W), .MIN_VAL(7'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_time.sec),
    .inc(tick_taken), .max_val(7'h59), .val(cur_time.sec), .wrap(sec_wrap));

  rtc_bcd_field #(.W(MIN_W), .MIN_VAL(7'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_time.min),
    .inc(sec_wrap), .max_val(7'h59), .val(cur_time.min), .wrap(min_wrap));

  rtc_bcd_field #(.W(HOUR_W), .MIN_VAL(6'h00)) u_hour (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_time.hour),
    .inc(min_wrap), .max_val(6'h23), .val(cur_time.hour), .wrap(hour_wrap));

  rtc_bcd_field #(.W(DOW_W), .MIN_VAL(3'd1)) u_dow (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_time.dow),
    .inc(hour_wrap), .max_val(3'd7), .val(cur_time.dow), .wrap(dow_wrap));

  rtc_bcd_field #(.W(DATE_W), .MIN_VAL(6'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_time.date),
    .inc(hour_wrap), .max_val(date_limit), .val(cur_time.date), .wrap(date_wrap));

  rtc_bcd_field #(.W(MONTH_W), .MIN_VAL(5'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_time.month),
    .inc(date_wrap), .max_val(5'h12), .val(cur_time.month), .wrap(month_wrap));

  rtc_bcd_field #(.W(YEAR_W), .MIN_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_time.year),
    .inc(month_wrap), .max_val(8'h99), .val(cur_time.year), .wrap(year_wrap));

  // R8
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !load) |=> $stable(cur_time));

  // R4
  month_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (month_roll && !load) |=> (cur_time.date == 6'h01) && (cur_time.month != $past(cur_time.month)));

  // R3
  dow_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dow_wrap && !load) |=> (cur_time.dow == 3'd1));

  // R6
  year_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (month_wrap && !year_wrap && !load) |=> (cur_time.year != $past(cur_time.year)));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  input  rtc_time_t         cur_time,
  output logic [REG_W-1:0]  rd_data,
  output rtc_time_t         stage_time,
  output logic              commit_lock,
  output logic              commit_fire,
  output logic              freeze_fire
);

  logic [1:0] ctrl_q;
  logic       ctrl_wr;
  rtc_time_t  view_time;

  assign ctrl_wr     = wr_en && (addr == A_CTRL);
  assign commit_lock = ctrl_q[CTRL_COMMIT];
  assign commit_fire = ctrl_wr && ctrl_q[CTRL_COMMIT] && !wr_data[CTRL_COMMIT];
  assign freeze_fire = ctrl_wr && !ctrl_q[CTRL_FREEZE] && wr_data[CTRL_FREEZE];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= 2'b00;
    else if (ctrl_wr) ctrl_q <= wr_data[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_time <= time_at_reset();
    end else if (wr_en) begin
      case (addr)
        A_SEC:   stage_time.sec   <= wr_data[SEC_W-1:0];
        A_MIN:   stage_time.min   <= wr_data[MIN_W-1:0];
        A_HOUR:  stage_time.hour  <= wr_data[HOUR_W-1:0];
        A_DOW:   stage_time.dow   <= wr_data[DOW_W-1:0];
        A_DATE:  stage_time.date  <= wr_data[DATE_W-1:0];
        A_MONTH: stage_time.month <= wr_data[MONTH_W-1:0];
        A_YEAR:  stage_time.year  <= wr_data[YEAR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           view_time <= time_at_reset();
    else if (freeze_fire) view_time <= cur_time;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = 8'(ctrl_q);
      A_SEC:   rd_data = 8'(view_time.sec);
      A_MIN:   rd_data = 8'(view_time.min);
      A_HOUR:  rd_data = 8'(view_time.hour);
      A_DOW:   rd_data = 8'(view_time.dow);
      A_DATE:  rd_data = 8'(view_time.date);
      A_MONTH: rd_data = 8'(view_time.month);
      A_YEAR:  rd_data = 8'(view_time.year);
      default: rd_data = '0;
    endcase
  end

  // R10
  freeze_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_fire |=> (view_time == $past(cur_time)));

  // R11
  view_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_FREEZE] && $past(ctrl_q[CTRL_FREEZE])) |-> $stable(view_time));

  // R12
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rd_data[7:2] == 6'd0));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data
);

  rtc_time_t core_time;
  rtc_time_t stage_time;
  logic      commit_lock;
  logic      commit_fire;
  logic      freeze_fire;
  logic      tick_taken;
  logic      day_roll;
  logic      month_roll;

  rtc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .cur_time(core_time), .rd_data(rd_data), .stage_time(stage_time),
    .commit_lock(commit_lock), .commit_fire(commit_fire), .freeze_fire(freeze_fire));

  rtc_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .lock(commit_lock),
    .load(commit_fire), .load_time(stage_time), .cur_time(core_time),
    .tick_taken(tick_taken), .day_roll(day_roll), .month_roll(month_roll));

  // R9
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (core_time == $past(stage_time)));

  // R8
  no_tick_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_lock |-> !tick_taken);

  // R2
  day_roll_hour_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_roll && !commit_fire) |=> (core_time.hour == 6'h00) && (core_time.min == 7'h00));

endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] rt [1:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
    end
  endtask

  task automatic grab(input logic lock_bit);
    wr(4'd0, {6'd0, lock_bit, 1'b1});
    for (int i = 1; i <= 7; i++) rd(4'(i), rt[i]);
    wr(4'd0, {6'd0, lock_bit, 1'b0});
  endtask

  task automatic expect_time(input string req, input logic [7:0] s, input logic [7:0] m,
                             input logic [7:0] h, input logic [7:0] dw, input logic [7:0] dt,
                             input logic [7:0] mo, input logic [7:0] y);
    check(req, "sec",   rt[1], s);
    check(req, "min",   rt[2], m);
    check(req, "hour",  rt[3], h);
    check(req, "dow",   rt[4], dw);
    check(req, "date",  rt[5], dt);
    check(req, "month", rt[6], mo);
    check(req, "year",  rt[7], y);
  endtask

  task automatic stage(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                       input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                       input logic [7:0] y);
    wr(4'd1, s); wr(4'd2, m); wr(4'd3, h); wr(4'd4, dw);
    wr(4'd5, dt); wr(4'd6, mo); wr(4'd7, y);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] y);
    stage(s, m, h, dw, dt, mo, y);
    wr(4'd0, 8'h02);
    wr(4'd0, 8'h00);
  endtask

  // Day-end test for a given date; returns the date/month after one tick.
  task automatic day_end(input string req, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] y, input logic [7:0] exp_dt, input logic [7:0] exp_mo);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, dt, mo, y);
    tick(1);
    grab(1'b0);
    check(req, "date after day end", rt[5], exp_dt);
    check(req, "month after day end", rt[6], exp_mo);
    check(req, "year kept", rt[7], y);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 1; i <= 7; i++) rd(4'(i), rt[i]);
    expect_time("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    rd(4'd0, v);
    check("R1", "ctrl at reset", v, 8'h00);
  endtask

  task automatic t_rollover();
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick(1);
    grab(1'b0);
    expect_time("R2", 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick(1);
    grab(1'b0);
    expect_time("R6", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    check("R3", "dow 7 to 1", rt[4], 8'h01);
    set_time(8'h59, 8'h59, 8'h09, 8'h03, 8'h10, 8'h05, 8'h40);
    tick(1);
    grab(1'b0);
    expect_time("R2", 8'h00, 8'h00, 8'h10, 8'h03, 8'h10, 8'h05, 8'h40);
  endtask

  task automatic t_month_len();
    day_end("R4", 8'h30, 8'h04, 8'h24, 8'h01, 8'h05);
    day_end("R4", 8'h30, 8'h01, 8'h24, 8'h31, 8'h01);
    day_end("R4", 8'h31, 8'h08, 8'h24, 8'h01, 8'h09);
    day_end("R4", 8'h30, 8'h11, 8'h24, 8'h01, 8'h12);
  endtask

  task automatic t_february();
    day_end("R5", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    day_end("R5", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    day_end("R5", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    day_end("R5", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
    day_end("R5", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
    day_end("R5", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
  endtask

  task automatic t_stage_isolated();
    logic [7:0] v;
    set_time(8'h30, 8'h20, 8'h10, 8'h04, 8'h15, 8'h06, 8'h33);
    grab(1'b0);
    stage(8'h05, 8'h06, 8'h07, 8'h01, 8'h02, 8'h03, 8'h04);
    rd(4'd1, v);
    check("R7", "read copy after staging", v, 8'h30);
    wr(4'd9, 8'h55);
    rd(4'd9, v);
    check("R7", "unmapped address reads zero", v, 8'h00);
    tick(1);
    grab(1'b0);
    expect_time("R7", 8'h31, 8'h20, 8'h10, 8'h04, 8'h15, 8'h06, 8'h33);
  endtask

  task automatic t_commit();
    logic [7:0] v;
    set_time(8'h10, 8'h11, 8'h12, 8'h05, 8'h20, 8'h07, 8'h50);
    stage(8'h45, 8'h44, 8'h13, 8'h03, 8'h15, 8'h06, 8'h21);
    wr(4'd0, 8'h02);
    rd(4'd0, v);
    check("R12", "ctrl readback commit", v, 8'h02);
    tick(3);
    grab(1'b1);
    expect_time("R8", 8'h10, 8'h11, 8'h12, 8'h05, 8'h20, 8'h07, 8'h50);
    wr(4'd0, 8'h00);
    grab(1'b0);
    expect_time("R9", 8'h45, 8'h44, 8'h13, 8'h03, 8'h15, 8'h06, 8'h21);
    tick(1);
    grab(1'b0);
    check("R9", "resume from copied sec", rt[1], 8'h46);
  endtask

  task automatic t_freeze();
    logic [7:0] v;
    set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(4'd0, 8'h01);
    rd(4'd0, v);
    check("R12", "ctrl readback freeze", v, 8'h01);
    rd(4'd1, v);
    check("R10", "capture on rise", v, 8'h05);
    tick(2);
    rd(4'd1, v);
    check("R11", "held while freeze set", v, 8'h05);
    wr(4'd0, 8'h01);
    rd(4'd1, v);
    check("R11", "rewrite of 1 no capture", v, 8'h05);
    wr(4'd0, 8'h00);
    wr(4'd0, 8'h01);
    rd(4'd1, v);
    check("R10", "new capture after 0 to 1", v, 8'h07);
    wr(4'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rollover();
    t_month_len();
    t_february();
    t_stage_isolated();
    t_commit();
    t_freeze();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule